// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the configuration entry point of a multi-function I/O controller. It answers at two adjacent byte addresses: an index port at the base and a data port at base plus one. A strap input chooses which of two base addresses the port decodes. The port stays locked until software writes the key byte twice in a row to the index port. A single exit byte written to the index port locks it again.

While unlocked, an index write selects a register, and data-port reads and writes reach that register. Indexes below 0x30 are global: a logical-device select, the device identity, the revision and a read-only strap report. Indexes 0x30 and up are banked by the logical-device select. The port itself holds the activation bit of every logical device. Every banked write is also sent to the attached logical device as a one-cycle strobe that carries the bank, the index and the data. Banked reads other than activation come back from that device.

The key detector is a three-state machine. LOCKED moves to KEY_HALF on an index write of 0x87. KEY_HALF moves to OPEN on a second index write of 0x87, and back to LOCKED on any other index write. OPEN moves to LOCKED on an index write of 0xAA. Data-port traffic never moves the machine.

Top module: `cfgp_port`

## Requirements
- R1: After reset the port is locked, the index and logical-device select are 0x00, every activation bit is 0, and `rd_valid` and `ldev_wr` are low.
- R2: With `strap_hi`=0 the index port is at BASE_LO (0x2E) and the data port at BASE_LO+1. With `strap_hi`=1 they are at BASE_HI (0x4E) and BASE_HI+1. Accesses to any other address give no `rd_valid` and change no state. A read answers one cycle after its strobe, with `rd_valid` high for one cycle.
- R3: Two back-to-back index writes of 0x87 unlock the port. `unlocked` is high in the cycle after the second write.
- R4: Any other index write that follows a first 0x87 returns the detector to LOCKED. So 0x87, 0x00, 0x87 leaves the port locked, and one further 0x87 unlocks it.
- R5: An index write of 0xAA while unlocked locks the port. It leaves the latched index unchanged.
- R6: While locked, data-port reads return 0xFF and data-port writes change nothing.
- R7: An index-port read returns the latched index while unlocked and 0xFF while locked. Index writes while locked do not change the index.
- R8: Index 0x20 reads DEV_ID, 0x21 reads DEV_REV, and 0x26 reads the strap in bit 6 with all other bits 0. Writes to these indexes are ignored.
- R9: Index 0x07 is a read/write byte that holds the logical-device select.
- R10: Banked index 0x30 holds one activation bit per logical device in bit 0, and reads back as {7'b0, bit}. `ldev_active[n]` shows the bit of device n.
- R11: A data write to an index of 0x30 or above, with the select below NUM_LDEV, pulses `ldev_wr` for one cycle in the next cycle. `ldev_bank`, `ldev_index` and `ldev_wdata` carry the select, the index and the byte.
- R12: A banked read at an index other than 0x30 returns `ldev_rdata`. With the select at NUM_LDEV or above, banked reads return 0xFF, and banked writes give no strobe and change no activation bit.
- R13: Global indexes other than 0x07, 0x20, 0x21 and 0x26 read 0x00, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write byte |
| strap_hi | input | 1 | Base select strap: 0 selects BASE_LO, 1 selects BASE_HI |
| rd_data | output | 8 | Read byte, valid with rd_valid |
| rd_valid | output | 1 | Read answer, one cycle after a decoded read |
| unlocked | output | 1 | Port is in configuration mode |
| ldev_wr | output | 1 | Banked register write strobe |
| ldev_bank | output | 8 | Current logical-device select |
| ldev_index | output | 8 | Current latched index |
| ldev_wdata | output | 8 | Byte of the banked write |
| ldev_rdata | input | 8 | Read-back from the selected logical device register |
| ldev_active | output | NUM_LDEV | Activation bit of each logical device |

## Verification
The unlock detector is tried with a broken key (0x87, 0x00, 0x87) followed by a completing 0x87. This separates a detector that needs consecutive key bytes from one that only counts them. Register access is tried both locked and unlocked at the same index. This shows that the gate blocks data writes and not just reads. Banked accesses use two in-range banks and one out-of-range bank, which shows that banking and range gating act on the strobe, the activation bits and the read mux. Switching the strap shows that the port answers only at the selected base pair, and that an unlock sequence sent to the other base has no effect.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_t;

    localparam logic [7:0] KEY_BYTE      = 8'h87;
    localparam logic [7:0] EXIT_BYTE     = 8'hAA;
    localparam logic [7:0] IDX_LDSEL     = 8'h07;
    localparam logic [7:0] IDX_IDENT     = 8'h20;
    localparam logic [7:0] IDX_REVISION  = 8'h21;
    localparam logic [7:0] IDX_STRAPS    = 8'h26;
    localparam logic [7:0] IDX_BANK_LOW  = 8'h30;
    localparam logic [7:0] IDX_ACTIVATE  = 8'h30;
    localparam int         STRAP_POS     = 6;
    localparam logic [7:0] IDLE_BYTE     = 8'hFF;

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_LO = 16'h002E,
    parameter logic [ADDR_W-1:0] BASE_HI = 16'h004E
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              strap_hi,
    output logic              hit_idx,
    output logic              hit_dat
);
    logic [ADDR_W-1:0] base;

    always_comb begin
        base    = strap_hi ? BASE_HI : BASE_LO;
        hit_idx = (addr == base);
        hit_dat = (addr == base + ADDR_W'(1));
    end
endmodule

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm
    import cfgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       open_o,
    output logic       latch_idx
);
    key_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KS_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_LOCKED: if (idx_wr && wdata == KEY_BYTE) state_d = KS_HALF;
            KS_HALF:   if (idx_wr) state_d = (wdata == KEY_BYTE) ? KS_OPEN : KS_LOCKED;
            KS_OPEN:   if (idx_wr && wdata == EXIT_BYTE) state_d = KS_LOCKED;
            default:   state_d = KS_LOCKED;
        endcase
    end

    always_comb begin
        open_o    = (state_q == KS_OPEN);
        latch_idx = open_o && idx_wr && (wdata != EXIT_BYTE);
    end
endmodule

// File: rtl/cfgp_regs.sv
module cfgp_regs
    import cfgp_pkg::*;
#(
    parameter int         NUM_LDEV = 12,
    parameter logic [7:0] DEV_ID   = 8'h5C,
    parameter logic [7:0] DEV_REV  = 8'h13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                open_i,
    input  logic                latch_idx,
    input  logic                idx_rd,
    input  logic                dat_wr,
    input  logic                dat_rd,
    input  logic [7:0]          wdata,
    input  logic                strap_hi,
    input  logic [7:0]          ldev_rdata,
    output logic [7:0]          rd_data,
    output logic                rd_valid,
    output logic                ldev_wr,
    output logic [7:0]          ldev_bank,
    output logic [7:0]          ldev_index,
    output logic [7:0]          ldev_wdata,
    output logic [NUM_LDEV-1:0] ldev_active
);
    localparam logic [7:0] LDEV_LIMIT = 8'(NUM_LDEV);

    logic [7:0]          index_q, ldsel_q, rd_q, wbyte_q, rd_d;
    logic                rdv_q, strobe_q;
    logic [NUM_LDEV-1:0] active_q, act_hit;
    logic                sel_ok, banked, bank_wr, act_wr, act_sel;

    always_comb begin
        sel_ok  = (ldsel_q < LDEV_LIMIT);
        banked  = (index_q >= IDX_BANK_LOW);
        bank_wr = open_i && dat_wr && banked && sel_ok;
        act_wr  = bank_wr && (index_q == IDX_ACTIVATE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= 8'h00;
            ldsel_q <= 8'h00;
        end else begin
            if (latch_idx) index_q <= wdata;
            if (open_i && dat_wr && index_q == IDX_LDSEL) ldsel_q <= wdata;
        end
    end

    for (genvar g = 0; g < NUM_LDEV; g++) begin : g_act
        always_ff @(posedge clk) begin
            if (!rst_n)                             active_q[g] <= 1'b0;
            else if (act_wr && ldsel_q == 8'(g))    active_q[g] <= wdata[0];
        end
        assign act_hit[g] = active_q[g] && (ldsel_q == 8'(g));
    end

    assign act_sel = |act_hit;

    always_comb begin
        rd_d = IDLE_BYTE;
        if (idx_rd) begin
            rd_d = open_i ? index_q : IDLE_BYTE;
        end else if (open_i) begin
            unique case (index_q)
                IDX_LDSEL:    rd_d = ldsel_q;
                IDX_IDENT:    rd_d = DEV_ID;
                IDX_REVISION: rd_d = DEV_REV;
                IDX_STRAPS:   rd_d = 8'({strap_hi}) << STRAP_POS;
                default: begin
                    if (!banked)                       rd_d = 8'h00;
                    else if (!sel_ok)                  rd_d = IDLE_BYTE;
                    else if (index_q == IDX_ACTIVATE)  rd_d = {7'b0, act_sel};
                    else                               rd_d = ldev_rdata;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q     <= 8'h00;
            rdv_q    <= 1'b0;
            strobe_q <= 1'b0;
            wbyte_q  <= 8'h00;
        end else begin
            rdv_q    <= idx_rd || dat_rd;
            if (idx_rd || dat_rd) rd_q <= rd_d;
            strobe_q <= bank_wr;
            if (bank_wr) wbyte_q <= wdata;
        end
    end

    assign rd_data     = rd_q;
    assign rd_valid    = rdv_q;
    assign ldev_wr     = strobe_q;
    assign ldev_bank   = ldsel_q;
    assign ldev_index  = index_q;
    assign ldev_wdata  = wbyte_q;
    assign ldev_active = active_q;
endmodule

// File: rtl/cfgp_port.sv
module cfgp_port
    import cfgp_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                NUM_LDEV = 12,
    parameter logic [ADDR_W-1:0] BASE_LO  = 16'h002E,
    parameter logic [ADDR_W-1:0] BASE_HI  = 16'h004E,
    parameter logic [7:0]        DEV_ID   = 8'h5C,
    parameter logic [7:0]        DEV_REV  = 8'h13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [7:0]          bus_wdata,
    input  logic                strap_hi,
    output logic [7:0]          rd_data,
    output logic                rd_valid,
    output logic                unlocked,
    output logic                ldev_wr,
    output logic [7:0]          ldev_bank,
    output logic [7:0]          ldev_index,
    output logic [7:0]          ldev_wdata,
    input  logic [7:0]          ldev_rdata,
    output logic [NUM_LDEV-1:0] ldev_active
);
    logic hit_idx, hit_dat, open_w, latch_idx;

    cfgp_decode #(.ADDR_W(ADDR_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)) u_decode (
        .addr     (bus_addr),
        .strap_hi (strap_hi),
        .hit_idx  (hit_idx),
        .hit_dat  (hit_dat)
    );

    cfgp_key_fsm u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (bus_wr && hit_idx),
        .wdata     (bus_wdata),
        .open_o    (open_w),
        .latch_idx (latch_idx)
    );

    cfgp_regs #(.NUM_LDEV(NUM_LDEV), .DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_i      (open_w),
        .latch_idx   (latch_idx),
        .idx_rd      (bus_rd && hit_idx),
        .dat_wr      (bus_wr && hit_dat),
        .dat_rd      (bus_rd && hit_dat),
        .wdata       (bus_wdata),
        .strap_hi    (strap_hi),
        .ldev_rdata  (ldev_rdata),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .ldev_wr     (ldev_wr),
        .ldev_bank   (ldev_bank),
        .ldev_index  (ldev_index),
        .ldev_wdata  (ldev_wdata),
        .ldev_active (ldev_active)
    );

    assign unlocked = open_w;
endmodule

// File: rtl/cfgp_port_chk.sv
module cfgp_port_chk #(
    parameter int                ADDR_W   = 16,
    parameter int                NUM_LDEV = 12,
    parameter logic [ADDR_W-1:0] BASE_LO  = 16'h002E,
    parameter logic [ADDR_W-1:0] BASE_HI  = 16'h004E
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [7:0]          bus_wdata,
    input logic                strap_hi,
    input logic [7:0]          rd_data,
    input logic                rd_valid,
    input logic                unlocked,
    input logic                ldev_wr,
    input logic [NUM_LDEV-1:0] ldev_active
);
    logic [ADDR_W-1:0] base;
    logic at_idx, at_dat;
    assign base   = strap_hi ? BASE_HI : BASE_LO;
    assign at_idx = (bus_addr == base);
    assign at_dat = (bus_addr == base + ADDR_W'(1));

    assert_answer_needs_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(bus_rd));

    assert_unlock_after_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> $past(bus_wr && at_idx && bus_wdata == 8'h87));

    assert_wrong_byte_stays_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && bus_wr && at_idx && bus_wdata != 8'h87) |=> !unlocked);

    assert_exit_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (unlocked && bus_wr && at_idx && bus_wdata == 8'hAA) |=> !unlocked);

    assert_locked_read_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && at_dat && !unlocked) |=> (rd_valid && rd_data == 8'hFF));

    assert_active_only_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && unlocked) |=> $stable(ldev_active));

    assert_strobe_from_open_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ldev_wr |-> $past(bus_wr && unlocked));
endmodule

bind cfgp_port cfgp_port_chk #(
    .ADDR_W(ADDR_W), .NUM_LDEV(NUM_LDEV), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)
) i_cfgp_port_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .strap_hi(strap_hi), .rd_data(rd_data), .rd_valid(rd_valid),
    .unlocked(unlocked), .ldev_wr(ldev_wr), .ldev_active(ldev_active)
);

// File: tb/test_cfgp_port.sv
`timescale 1ns/1ps
module test_cfgp_port;
    localparam int         NL   = 12;
    localparam logic [7:0] ID   = 8'h5C;
    localparam logic [7:0] REV  = 8'h13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, strap_hi = 1'b0;
    logic [7:0]  bus_wdata = 8'h0;
    logic [7:0]  rd_data, ldev_bank, ldev_index, ldev_wdata, ldev_rdata;
    logic        rd_valid, unlocked, ldev_wr;
    logic [NL-1:0] ldev_active;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    assign ldev_rdata = ldev_index ^ ldev_bank ^ 8'h3C;

    cfgp_port i_cfgp_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .strap_hi(strap_hi), .rd_data(rd_data), .rd_valid(rd_valid),
        .unlocked(unlocked), .ldev_wr(ldev_wr), .ldev_bank(ldev_bank), .ldev_index(ldev_index),
        .ldev_wdata(ldev_wdata), .ldev_rdata(ldev_rdata), .ldev_active(ldev_active)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string req);
        @(negedge clk);
        exp_q.push_back(e); tag_q.push_back(req);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd_none(input logic [15:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R2 missing answers actual=%0d expected=0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: pops the scoreboard on every answer
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R2 unexpected answer actual=%0h expected=none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 locked", unlocked, 0);
        check("R1 strobe", ldev_wr, 0);
        check("R1 active", ldev_active, 0);
        check("R1 valid", rd_valid, 0);
        rd(16'h2F, 8'hFF, "R6 locked read");
        rd(16'h2E, 8'hFF, "R7 locked index read");
        wr(16'h2E, 8'h07);            // locked index write: no latch
        wr(16'h2F, 8'h05);            // locked data write: ignored
        // R4 broken key then R3 completing key
        wr(16'h2E, 8'h87);
        wr(16'h2E, 8'h00);
        check("R4 broken key", unlocked, 0);
        wr(16'h2E, 8'h87);
        check("R4 single key", unlocked, 0);
        wr(16'h2E, 8'h87);
        check("R3 unlock", unlocked, 1);
        rd(16'h2E, 8'h00, "R7 index unchanged while locked");
        wr(16'h2E, 8'h07);
        rd(16'h2F, 8'h00, "R9 R6 select untouched");
        wr(16'h2F, 8'h03);
        rd(16'h2F, 8'h03, "R9 select readback");
        rd(16'h2E, 8'h07, "R7 index readback");
        wr(16'h2E, 8'h20); rd(16'h2F, ID, "R8 ident");
        wr(16'h2F, 8'h00); rd(16'h2F, ID, "R8 ident write ignored");
        wr(16'h2E, 8'h21); rd(16'h2F, REV, "R8 revision");
        wr(16'h2E, 8'h26); rd(16'h2F, 8'h00, "R8 strap low");
        wr(16'h2F, 8'hFF); rd(16'h2F, 8'h00, "R8 strap write ignored");
        wr(16'h2E, 8'h10); wr(16'h2F, 8'h77); rd(16'h2F, 8'h00, "R13 unassigned");
        // activation in bank 3
        wr(16'h2E, 8'h30);
        rd(16'h2F, 8'h00, "R10 inactive");
        wr(16'h2F, 8'h01);
        check("R11 strobe", ldev_wr, 1);
        check("R11 bank", ldev_bank, 3);
        check("R11 index", ldev_index, 8'h30);
        check("R11 data", ldev_wdata, 8'h01);
        @(negedge clk);
        check("R11 one cycle", ldev_wr, 0);
        check("R10 active vec", ldev_active, 12'h008);
        rd(16'h2F, 8'h01, "R10 readback");
        wr(16'h2F, 8'hFE); rd(16'h2F, 8'h00, "R10 clear");
        wr(16'h2F, 8'hFF); rd(16'h2F, 8'h01, "R10 only bit0");
        // bank 5
        wr(16'h2E, 8'h07); wr(16'h2F, 8'h05);
        wr(16'h2E, 8'h30); rd(16'h2F, 8'h00, "R10 separate bank");
        wr(16'h2F, 8'h01);
        check("R10 two banks", ldev_active, 12'h028);
        wr(16'h2E, 8'hF6); wr(16'h2F, 8'h5A);
        check("R11 strobe F6", ldev_wr, 1);
        check("R11 bank5", ldev_bank, 5);
        check("R11 index F6", ldev_index, 8'hF6);
        check("R11 data 5A", ldev_wdata, 8'h5A);
        rd(16'h2F, 8'hF6 ^ 8'h05 ^ 8'h3C, "R12 device readback");
        // out-of-range bank
        wr(16'h2E, 8'h07); wr(16'h2F, 8'(NL));
        wr(16'h2E, 8'h30); wr(16'h2F, 8'h01);
        check("R12 no strobe", ldev_wr, 0);
        check("R12 active kept", ldev_active, 12'h028);
        rd(16'h2F, 8'hFF, "R12 range read");
        // exit and locked write
        wr(16'h2E, 8'h07); wr(16'h2F, 8'h05); wr(16'h2E, 8'h30);
        wr(16'h2E, 8'hAA);
        check("R5 exit", unlocked, 0);
        rd(16'h2F, 8'hFF, "R6 read after exit");
        wr(16'h2F, 8'h00);
        check("R6 no strobe", ldev_wr, 0);
        wr(16'h2E, 8'h87); wr(16'h2E, 8'h87);
        check("R3 relock", unlocked, 1);
        rd(16'h2E, 8'h30, "R5 index kept");
        rd(16'h2F, 8'h01, "R6 locked write ignored");
        // strap switch
        wr(16'h2E, 8'hAA);
        strap_hi = 1'b1;
        wr(16'h2E, 8'h87); wr(16'h2E, 8'h87);
        check("R2 old base no unlock", unlocked, 0);
        rd_none(16'h2F);
        rd_none(16'h60);
        wr(16'h4E, 8'h87); wr(16'h4E, 8'h87);
        check("R2 new base unlock", unlocked, 1);
        wr(16'h4E, 8'h26); rd(16'h4F, 8'h40, "R8 R2 strap high");
        rd(16'h4E, 8'h26, "R2 index at new base");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule